// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block holds wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, date, month (with a century flag in its top bit) and a two-digit year. A base tick enable, expected at a fixed integer rate (nominally 32.768 kHz), feeds a sub-second prescaler. Every `PRESCALE` ticks the seconds advance by one. Carries run through minutes, hours, day and date, then month and year. Month lengths and leap years are applied on the way.

Hours can be kept in 24-hour form or in 12-hour form with a PM flag. Bit 6 of the hour byte selects the form. Software loads any field through a simple write port of address, data and strobe. All seven bytes are visible at all times on parallel outputs. Writing the seconds byte restarts the sub-second phase. A 1 Hz square wave follows that phase: it is low for the first half of each second and high for the second half.

Top module: `ctc_calendar`

## Requirements
- R1: After reset the bytes read seconds 00, minutes 00, hours 00 (24-hour form), day of week 1, date 01, month 01 with century flag 0, and year 00, and the square wave is low.
- R2: The seconds advance by one BCD step after every `PRESCALE` cycles with `tick_i` high. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours.
- R3: With hour bit 6 clear (24-hour form), bits 5:0 count BCD 00..23: 09 goes to 10, 19 goes to 20, and 23 goes to 00 with a carry into the day.
- R4: With hour bit 6 set (12-hour form), bit 5 is PM and bits 4:0 hold 1..12. The sequence is 11 AM to 12 PM, 12 to 1 with PM kept, and 11 PM to 12 AM (0x71 to 0x52) with a carry into the day.
- R5: The day of week counts 1..7 and steps at each midnight carry, with 7 wrapping to 1.
- R6: On the midnight carry, the date rolls to 01 and the month steps when the date equals the month's length. Months 04, 06, 09 and 11 have 30 days and February has 28 or 29. All other months have 31. Month 12 rolls to 01 and carries into the year.
- R7: February has 29 days when the BCD year is a multiple of 4, with year 00 counted as leap.
- R8: When the year wraps from 99 to 00, month bit 7 (the century flag) inverts. Otherwise the flag is unchanged by month and year stepping.
- R9: A write to the seconds byte clears the prescaler. `sq_o` is high exactly while at least `PRESCALE/2` ticks have passed since the last second boundary. It is low again at the next seconds step, `PRESCALE` ticks after the write.
- R10: A write to a byte in the same cycle as that byte's increment wins; the carry into that byte is lost.
- R11: Address map: 0 seconds (mask 0x7F), 1 minutes (0x7F), 2 hours (0x7F), 3 day (0x07), 4 date (0x3F), 5 month (0x9F), 6 year (0xFF). A masked-off bit is stored as 0. A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick enable, one cycle per base period |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Byte address of the write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours: bit 6 form select, bit 5 PM or tens-of-20, BCD below |
| dow_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month BCD in bits 4:0, century flag in bit 7 |
| year_o | output | 8 | Year, BCD |
| sq_o | output | 1 | 1 Hz square wave locked to the seconds phase |

## Verification
The range assertions on the hour and day-of-week bytes assume that software only writes legal BCD values for the selected hour form and for the day. The carry-chain assertions assume that month, date and year were loaded with a consistent calendar entry. The bench writes only such values; it also sends out-of-range upper bits, but it picks them so that the masks leave a legal byte. It preloads the bytes with `tick_i` held low and writes seconds last, so that each run starts on a fresh second boundary. The bench then applies whole multiples of `PRESCALE` ticks, except in the tests that probe the mid-second phase and write collisions.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam logic [2:0] ADDR_SEC   = 3'd0;
  localparam logic [2:0] ADDR_MIN   = 3'd1;
  localparam logic [2:0] ADDR_HOUR  = 3'd2;
  localparam logic [2:0] ADDR_DOW   = 3'd3;
  localparam logic [2:0] ADDR_DATE  = 3'd4;
  localparam logic [2:0] ADDR_MONTH = 3'd5;
  localparam logic [2:0] ADDR_YEAR  = 3'd6;

  localparam logic [7:0] MASK_SEC   = 8'h7F;
  localparam logic [7:0] MASK_MIN   = 8'h7F;
  localparam logic [7:0] MASK_HOUR  = 8'h7F;
  localparam logic [7:0] MASK_DOW   = 8'h07;
  localparam logic [7:0] MASK_DATE  = 8'h3F;
  localparam logic [7:0] MASK_MONTH = 8'h9F;
  localparam logic [7:0] MASK_YEAR  = 8'hFF;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of 4 in BCD: even tens with 0/4/8, odd tens with 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic step_o,
  output logic half_o
);
  localparam int unsigned CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
  localparam logic [CW-1:0] HALF = CW'(PRESCALE / 2);

  logic [CW-1:0] cnt_q;

  assign step_o = tick_i && !clr_i && (cnt_q == LAST);
  assign half_o = (cnt_q >= HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == LAST)   cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PRESC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !half_o)); // R9
  AST_PRESC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_PRESC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/ctc_time_chain.sv
module ctc_time_chain
  import ctc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_step_o
);
  logic [7:0] sec_q, min_q, hour_q, hour_nx;
  logic wr_sec, wr_min, wr_hour;
  logic min_step, hour_step, hour_last;

  assign wr_sec  = wr_en_i && (wr_addr_i == ADDR_SEC);
  assign wr_min  = wr_en_i && (wr_addr_i == ADDR_MIN);
  assign wr_hour = wr_en_i && (wr_addr_i == ADDR_HOUR);

  assign min_step  = step_i && (sec_q == 8'h59);
  assign hour_step = min_step && (min_q == 8'h59);

  // 12-hour form: last hour of the day is 11 PM
  assign hour_last = hour_q[6] ? (hour_q[5] && hour_q[4:0] == 5'h11)
                               : (hour_q[5:0] == 6'h23);
  assign day_step_o = hour_step && hour_last;

  always_comb begin
    hour_nx = hour_q;
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h12)      hour_nx = {hour_q[7:5], 5'h01};
      else if (hour_q[4:0] == 5'h11) hour_nx = {hour_q[7:6], ~hour_q[5], 5'h12};
      else                           hour_nx = {hour_q[7:5], 5'(bcd_inc({3'b000, hour_q[4:0]}))};
    end else begin
      if (hour_q[5:0] == 6'h23)      hour_nx = {hour_q[7:6], 6'h00};
      else                           hour_nx = {hour_q[7:6], 6'(bcd_inc({2'b00, hour_q[5:0]}))};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_sec)         sec_q <= wr_data_i & MASK_SEC;
      else if (step_i)    sec_q <= (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
      if (wr_min)         min_q <= wr_data_i & MASK_MIN;
      else if (min_step)  min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (wr_hour)        hour_q <= wr_data_i & MASK_HOUR;
      else if (hour_step) hour_q <= hour_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  AST_SEC_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q[3:0] <= 4'd9) && (sec_q[7:4] <= 4'd5)); // R2
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !wr_sec) |=> $stable(sec_q)); // R2
  AST_HOUR_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_q[6] ? (hour_q[4:0] != 5'h00 && hour_q[4:0] <= 5'h12)
              : (hour_q[5:0] <= 6'h23)); // R3
  AST_PM_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_step && !wr_hour && hour_q[6] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5]))); // R4
  AST_MIN_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_min |=> (min_q == ($past(wr_data_i) & MASK_MIN))); // R10
endmodule

// File: rtl/ctc_date_chain.sv
module ctc_date_chain
  import ctc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_step_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic [7:0] dow_q, date_q, month_q, year_q, mlen, mon_inc;
  logic wr_dow, wr_date, wr_month, wr_year;
  logic month_step, year_step, cent_flip;

  assign wr_dow   = wr_en_i && (wr_addr_i == ADDR_DOW);
  assign wr_date  = wr_en_i && (wr_addr_i == ADDR_DATE);
  assign wr_month = wr_en_i && (wr_addr_i == ADDR_MONTH);
  assign wr_year  = wr_en_i && (wr_addr_i == ADDR_YEAR);

  assign mlen       = month_len(month_q[4:0], is_leap(year_q));
  assign month_step = day_step_i && (date_q == mlen);
  assign year_step  = month_step && (month_q[4:0] == 5'h12);
  assign cent_flip  = year_step && (year_q == 8'h99);
  assign mon_inc    = bcd_inc({3'b000, month_q[4:0]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_dow)          dow_q <= wr_data_i & MASK_DOW;
      else if (day_step_i) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;
      if (wr_date)         date_q <= wr_data_i & MASK_DATE;
      else if (day_step_i) date_q <= (date_q == mlen) ? 8'h01 : bcd_inc(date_q);
      if (wr_month)        month_q <= wr_data_i & MASK_MONTH;
      else begin
        if (month_step)    month_q[4:0] <= (month_q[4:0] == 5'h12) ? 5'h01 : mon_inc[4:0];
        if (cent_flip)     month_q[7] <= ~month_q[7];
      end
      if (wr_year)         year_q <= wr_data_i & MASK_YEAR;
      else if (year_step)  year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign dow_o   = dow_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dow_q >= 8'h01) && (dow_q <= 8'h07)); // R5
  AST_MONTH_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (month_step && !wr_date) |=> (date_q == 8'h01)); // R6
  AST_CENTURY_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cent_flip && !wr_month) |=> (month_q[7] != $past(month_q[7]))); // R8
  AST_CENTURY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cent_flip && !wr_month) |=> $stable(month_q[7])); // R8
endmodule

// File: rtl/ctc_calendar.sv
module ctc_calendar
  import ctc_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sq_o
);
  logic sec_wr, sec_step, day_step;

  assign sec_wr = wr_en_i && (wr_addr_i == ADDR_SEC);

  ctc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (sec_wr),
    .step_o (sec_step),
    .half_o (sq_o)
  );

  ctc_time_chain u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (sec_step),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .day_step_o (day_step)
  );

  ctc_date_chain u_date (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .day_step_i (day_step),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .dow_o      (dow_o),
    .date_o     (date_o),
    .month_o    (month_o),
    .year_o     (year_o)
  );

  AST_ADDR7_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd7 && !tick_i)
      |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(dow_o)
           && $stable(date_o) && $stable(month_o) && $stable(year_o))); // R11
endmodule

// File: tb/tb_ctc_calendar.sv
module tb_ctc_calendar;
  localparam int unsigned P = 8;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec, mins, hour, dow, date, month, year;
  logic sq;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ctc_calendar #(.PRESCALE(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(mins), .hour_o(hour), .dow_o(dow),
    .date_o(date), .month_o(month), .year_o(year), .sq_o(sq)
  );

  // {sec,min,hour,dow,date,month,year} in, seconds to run, same seven out, requirement
  localparam logic [127:0] VEC [NV] = '{
    {56'h58_00_00_01_01_01_00, 8'd3, 56'h01_01_00_01_01_01_00, 8'd2},
    {56'h59_59_09_02_10_01_05, 8'd1, 56'h00_00_10_02_10_01_05, 8'd3},
    {56'h59_59_19_02_10_01_05, 8'd1, 56'h00_00_20_02_10_01_05, 8'd3},
    {56'h59_59_23_07_15_03_21, 8'd1, 56'h00_00_00_01_16_03_21, 8'd5},
    {56'h59_59_51_03_10_01_05, 8'd1, 56'h00_00_72_03_10_01_05, 8'd4},
    {56'h59_59_72_03_10_01_05, 8'd1, 56'h00_00_61_03_10_01_05, 8'd4},
    {56'h59_59_71_03_30_04_21, 8'd1, 56'h00_00_52_04_01_05_21, 8'd4},
    {56'h59_59_52_03_10_01_05, 8'd1, 56'h00_00_41_03_10_01_05, 8'd4},
    {56'h59_59_23_01_28_02_23, 8'd1, 56'h00_00_00_02_01_03_23, 8'd7},
    {56'h59_59_23_01_28_02_24, 8'd1, 56'h00_00_00_02_29_02_24, 8'd7},
    {56'h59_59_23_01_28_02_00, 8'd1, 56'h00_00_00_02_29_02_00, 8'd7},
    {56'h59_59_23_01_29_02_24, 8'd1, 56'h00_00_00_02_01_03_24, 8'd7},
    {56'h59_59_23_01_31_01_10, 8'd1, 56'h00_00_00_02_01_02_10, 8'd6},
    {56'h59_59_23_01_30_09_10, 8'd1, 56'h00_00_00_02_01_10_10, 8'd6},
    {56'h59_59_23_01_30_05_10, 8'd1, 56'h00_00_00_02_31_05_10, 8'd6},
    {56'h59_59_23_01_31_12_99, 8'd1, 56'h00_00_00_02_01_81_00, 8'd8},
    {56'h59_59_23_01_31_92_45, 8'd1, 56'h00_00_00_02_01_81_46, 8'd8},
    {56'h59_59_23_01_31_92_99, 8'd1, 56'h00_00_00_02_01_01_00, 8'd8}
  };

  function automatic string req_name(input logic [7:0] r);
    case (r)
      8'd2: return "R2";
      8'd3: return "R3";
      8'd4: return "R4";
      8'd5: return "R5";
      8'd6: return "R6";
      8'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] reg_at(input logic [2:0] a);
    case (a)
      3'd0: return sec;
      3'd1: return mins;
      3'd2: return hour;
      3'd3: return dow;
      3'd4: return date;
      3'd5: return month;
      default: return year;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input int k);
    tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] snap [7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "sec", sec, 8'h00);
    check("R1", "min", mins, 8'h00);
    check("R1", "hour", hour, 8'h00);
    check("R1", "dow", dow, 8'h01);
    check("R1", "date", date, 8'h01);
    check("R1", "month", month, 8'h01);
    check("R1", "year", year, 8'h00);
    check("R1", "sq", {7'd0, sq}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      for (int a = 1; a < 7; a++) write(3'(a), VEC[v][127-8*a -: 8]);
      write(3'd0, VEC[v][127:120]);
      run_ticks(int'(VEC[v][71:64]) * P);
      for (int a = 0; a < 7; a++)
        check(req_name(VEC[v][7:0]), $sformatf("vec%0d byte%0d", v, a),
              reg_at(3'(a)), VEC[v][63-8*a -: 8]);
    end

    // R9 square-wave phase after a seconds write
    write(3'd0, 8'h10);
    check("R9", "sq after write", {7'd0, sq}, 8'h00);
    run_ticks(P/2 - 1);
    check("R9", "sq before half", {7'd0, sq}, 8'h00);
    run_ticks(1);
    check("R9", "sq at half", {7'd0, sq}, 8'h01);
    run_ticks(P/2 - 1);
    check("R9", "sq late", {7'd0, sq}, 8'h01);
    check("R9", "sec not yet", sec, 8'h10);
    run_ticks(1);
    check("R9", "sec stepped", sec, 8'h11);
    check("R9", "sq low at step", {7'd0, sq}, 8'h00);
    // R9 rewrite mid-second restarts phase
    run_ticks(P/2 + 1);
    write(3'd0, 8'h20);
    check("R9", "sq cleared by write", {7'd0, sq}, 8'h00);
    run_ticks(P - 1);
    check("R9", "sec held after restart", sec, 8'h20);
    run_ticks(1);
    check("R9", "sec after restart", sec, 8'h21);

    // R10 minute write collides with minute carry
    write(3'd1, 8'h10);
    write(3'd0, 8'h59);
    run_ticks(P - 1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R10", "sec rolled", sec, 8'h00);
    check("R10", "min write wins", mins, 8'h33);
    // R10 seconds write collides with seconds step
    write(3'd0, 8'h59);
    run_ticks(P - 1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h42;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R10", "sec write wins", sec, 8'h42);
    check("R10", "no min carry", mins, 8'h33);

    // R11 address 7 has no effect
    for (int a = 0; a < 7; a++) snap[a] = reg_at(3'(a));
    write(3'd7, 8'hFF);
    for (int a = 0; a < 7; a++)
      check("R11", $sformatf("addr7 byte%0d", a), reg_at(3'(a)), snap[a]);
    // R11 write masks
    write(3'd0, 8'hD9);
    write(3'd1, 8'h85);
    write(3'd2, 8'hA3);
    write(3'd3, 8'hF5);
    write(3'd4, 8'hC7);
    write(3'd5, 8'hE9);
    write(3'd6, 8'h37);
    check("R11", "sec mask", sec, 8'h59);
    check("R11", "min mask", mins, 8'h05);
    check("R11", "hour mask", hour, 8'h23);
    check("R11", "dow mask", dow, 8'h05);
    check("R11", "date mask", date, 8'h07);
    check("R11", "month mask", month, 8'h89);
    check("R11", "year mask", year, 8'h37);

    finish_run();
  end
endmodule